// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read side of a serial configuration store. A loader clocks it, and it returns one stored bit per clock on a serial output. Inside it keeps a bit array of `DEPTH` entries. A synchronous write port fills the array while the device is deselected. The serial output is tri-state. It is modelled as a data bit plus an output-enable flag, so several outputs can be resolved as a wired bus outside the block.

Several instances can be chained to make a longer bitstream. The chip-enable input (`ce_n`, active low) of each downstream device is wired to the cascade output (`ceo_n`) of the device before it. The first device enables the next one one clock after its own last bit has gone out. This leaves one idle cycle on the bus. It also has a combined reset/output-enable pin, `rst_oe`, whose active level is set by the `RST_OE_HIGH` parameter. When `rst_oe` is active it clears the read position. When it is tied inactive, a finished device stays finished.

Top module: `cfg_stream_reader`

## Requirements
- R1: After `rst_n` is released, `dout_oe` is 0 and `ceo_n` is 1.
- R2: On each rising edge where `ce_n` is 0, `rst_oe` is inactive and bits remain, the block drives the bit at the current read position on `dout` with `dout_oe` at 1. It then advances the read position by one, starting from position 0.
- R3: On the edge after position `DEPTH-1` has been presented, while the block is still enabled, `ceo_n` goes to 0 and `dout_oe` goes to 0. The read position saturates at `DEPTH` and never wraps.
- R4: In a two-device chain whose second device takes `ce_n` from the first device's `ceo_n`, the wired bus carries all of the first array and then all of the second array, in address order. No two drivers are active at the same time.
- R5: An active `rst_oe` on an edge sets the read position to 0, `dout_oe` to 0 and `ceo_n` to 1. The next enabled edge presents position 0.
- R6: `rst_oe` is active high when `RST_OE_HIGH` is 1 and active low when it is 0.
- R7: An edge with `ce_n` at 1 (standby) leaves `dout_oe` at 0 and holds the read position. A later enabled edge resumes from the held position.
- R8: `wr_en` writes `wr_bit` to array position `wr_addr` only on an edge where `ce_n` is 1. A write attempted while `ce_n` is 0 leaves the array unchanged.
- R9: While `rst_oe` stays inactive, a device that has finished keeps `ceo_n` at 0 and `dout_oe` at 0, even with `ce_n` held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Power-up reset, active low |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| rst_oe | input | 1 | Read-position reset / output enable, polarity set by `RST_OE_HIGH` |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | $clog2(DEPTH) | Array write position |
| wr_bit | input | 1 | Array write data |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Serial data drive enable (0 means high impedance) |
| ceo_n | output | 1 | Cascade enable to the next device, active low |

## Verification
The hardest situation to reach is the hand-off inside a chain. The second device is enabled only by the first device's internal end-of-array state, and an interrupted stream must still splice cleanly across it. The stimulus loads two chained devices with distinct patterns and starts the stream. It parks the first device in standby part-way through, and it attempts an illegal write while streaming. It then lets the chain run to completion and compares the whole wired-bus sequence against the concatenated patterns. Only after that does it apply reset mid-stream. A third device, built with the opposite reset polarity, repeats the reset checks.

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader #(
  parameter int DEPTH       = 256,
  parameter bit RST_OE_HIGH = 1'b1,
  localparam int AW  = $clog2(DEPTH + 1),
  localparam int WAW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce_n,
  input  logic           rst_oe,
  input  logic           wr_en,
  input  logic [WAW-1:0] wr_addr,
  input  logic           wr_bit,
  output logic           dout,
  output logic           dout_oe,
  output logic           ceo_n
);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    addr;
  logic             clr;
  logic             more;

  assign clr  = RST_OE_HIGH ? rst_oe : ~rst_oe;
  assign more = addr < AW'(DEPTH);

  always_ff @(posedge clk)
    if (wr_en && ce_n) mem[wr_addr] <= wr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      addr    <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      ceo_n   <= 1'b1;
    end else if (!ce_n) begin
      if (more) begin
        dout    <= mem[addr[WAW-1:0]];
        dout_oe <= 1'b1;
        addr    <= addr + 1'b1;
      end else begin
        dout_oe <= 1'b0;
        ceo_n   <= 1'b0;
      end
    end else begin
      dout_oe <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_stream_reader_chk.sv
module cfg_stream_reader_chk #(
  parameter int DEPTH       = 256,
  parameter bit RST_OE_HIGH = 1'b1,
  localparam int AW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          rst_oe,
  input logic [AW-1:0] addr,
  input logic          dout_oe,
  input logic          ceo_n
);

  logic act;
  assign act = (rst_oe == RST_OE_HIGH);

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !act && addr < AW'(DEPTH)) |=> (dout_oe && addr == $past(addr) + 1'b1));

  a_r3_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !act && addr == AW'(DEPTH)) |=> (!ceo_n && !dout_oe));

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    addr <= AW'(DEPTH));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> (addr == '0 && ceo_n && !dout_oe));

  a_r7_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !act) |=> (!dout_oe && $stable(addr)));

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceo_n && !act) |=> (!ceo_n && !dout_oe));

endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(.DEPTH(DEPTH), .RST_OE_HIGH(RST_OE_HIGH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_oe(rst_oe),
  .addr(addr), .dout_oe(dout_oe), .ceo_n(ceo_n)
);

// File: tb/cfg_stream_reader_tb_top.sv
module cfg_stream_reader_tb_top;
  localparam int  D = 16;
  localparam real PERIOD = 10.0;
  localparam logic [15:0] PAT0 = 16'hA5C3, PAT1 = 16'h0FF1, PAT2 = 16'h6B2D;

  logic clk = 0, rst_n = 0, ce_n = 1, ce2_n = 1, rst_oe = 0, rst_oe2 = 1;
  logic [2:0] wr_en = '0;
  logic [3:0] wr_addr = '0;
  logic wr_bit = 0;
  logic [2:0] d, oe, ceo;
  int checks = 0, errors = 0;
  bit collect = 0;
  bit got[$];

  always #(PERIOD/2) clk = ~clk;

  cfg_stream_reader #(.DEPTH(D), .RST_OE_HIGH(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rst_oe(rst_oe), .wr_en(wr_en[0]),
    .wr_addr(wr_addr), .wr_bit(wr_bit), .dout(d[0]), .dout_oe(oe[0]), .ceo_n(ceo[0]));
  cfg_stream_reader #(.DEPTH(D), .RST_OE_HIGH(1'b1)) nxt_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ceo[0]), .rst_oe(rst_oe), .wr_en(wr_en[1]),
    .wr_addr(wr_addr), .wr_bit(wr_bit), .dout(d[1]), .dout_oe(oe[1]), .ceo_n(ceo[1]));
  cfg_stream_reader #(.DEPTH(D), .RST_OE_HIGH(1'b0)) low_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce2_n), .rst_oe(rst_oe2), .wr_en(wr_en[2]),
    .wr_addr(wr_addr), .wr_bit(wr_bit), .dout(d[2]), .dout_oe(oe[2]), .ceo_n(ceo[2]));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_addr[3];
  bit m_d[3], m_oe[3], m_ceo[3];
  logic [D-1:0] m_mem[3];

  always @(posedge clk) begin
    for (int i = 2; i >= 0; i--) begin
      bit ce, clr;
      ce  = (i == 0) ? ce_n : (i == 1) ? m_ceo[0] : ce2_n;
      clr = (i == 2) ? !rst_oe2 : rst_oe;
      if (wr_en[i] && ce) m_mem[i][wr_addr] = wr_bit;
      if (!rst_n || clr) begin
        m_addr[i] = 0; m_d[i] = 0; m_oe[i] = 0; m_ceo[i] = 1;
      end else if (!ce) begin
        if (m_addr[i] < D) begin
          m_d[i] = m_mem[i][m_addr[i]]; m_oe[i] = 1; m_addr[i]++;
        end else begin
          m_oe[i] = 0; m_ceo[i] = 0;
        end
      end else m_oe[i] = 0;
    end
    #(PERIOD/4);
    for (int i = 0; i < 3; i++) begin
      chk(oe[i] === m_oe[i], "R2/R7 dout_oe", int'(oe[i]), int'(m_oe[i]));
      chk(ceo[i] === m_ceo[i], "R3/R5 ceo_n", int'(ceo[i]), int'(m_ceo[i]));
      if (m_oe[i]) chk(d[i] === m_d[i], "R2 dout", int'(d[i]), int'(m_d[i]));
    end
    chk(!(oe[0] && oe[1]), "R4 single driver", int'(oe[1:0]), 1);
    if (collect && (oe[0] || oe[1])) got.push_back(oe[0] ? d[0] : d[1]);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit exp_s[$];
    step(3);
    rst_n = 1;
    step(1);
    for (int i = 0; i < 3; i++) begin
      chk(oe[i] == 0, "R1 dout_oe after reset", int'(oe[i]), 0);
      chk(ceo[i] == 1, "R1 ceo_n after reset", int'(ceo[i]), 1);
    end
    // R8 load while deselected
    for (int i = 0; i < 3; i++)
      for (int a = 0; a < D; a++) begin
        wr_en = 3'(1 << i); wr_addr = 4'(a);
        wr_bit = (i == 0) ? PAT0[a] : (i == 1) ? PAT1[a] : PAT2[a];
        step(1);
      end
    wr_en = '0;
    // chain stream with standby pause and illegal write
    collect = 1; ce_n = 0;
    step(5);
    wr_en = 3'b001; wr_addr = 4'd10; wr_bit = ~PAT0[10];
    step(1);
    wr_en = '0; ce_n = 1;
    step(1);
    chk(oe[0] == 0, "R7 standby drive off", int'(oe[0]), 0);
    step(2);
    ce_n = 0;
    step(40);
    collect = 0;
    chk(ceo[0] == 0 && ceo[1] == 0, "R3 both cascade low", int'(ceo[1:0]), 0);
    chk(oe[0] == 0 && oe[1] == 0, "R9 no restart", int'(oe[1:0]), 0);
    for (int a = 0; a < D; a++) exp_s.push_back(PAT0[a]);
    for (int a = 0; a < D; a++) exp_s.push_back(PAT1[a]);
    chk(got.size() == exp_s.size(), "R4 stream length", got.size(), exp_s.size());
    for (int k = 0; k < exp_s.size() && k < got.size(); k++)
      chk(got[k] == exp_s[k], (k == 10) ? "R8 ignored write" : "R4 stream bit", int'(got[k]), int'(exp_s[k]));
    // R5 reset after completion and mid-stream
    rst_oe = 1;
    step(1);
    chk(ceo[0] == 1 && oe[0] == 0, "R5 reset clears", int'({ceo[0], oe[0]}), 2);
    rst_oe = 0;
    step(1);
    chk(oe[0] == 1 && d[0] == PAT0[0], "R5 restart at bit 0", int'(d[0]), int'(PAT0[0]));
    step(3);
    rst_oe = 1;
    step(1);
    rst_oe = 0;
    step(1);
    chk(d[0] == PAT0[0], "R5 mid-stream restart", int'(d[0]), int'(PAT0[0]));
    ce_n = 1;
    // R6 active-low polarity device
    ce2_n = 0;
    step(4);
    chk(oe[2] == 1 && d[2] == PAT2[3], "R6 high level inactive", int'(d[2]), int'(PAT2[3]));
    rst_oe2 = 0;
    step(1);
    chk(oe[2] == 0 && ceo[2] == 1, "R6 low level resets", int'(oe[2]), 0);
    rst_oe2 = 1;
    step(1);
    chk(d[2] == PAT2[0], "R6 restart bit 0", int'(d[2]), int'(PAT2[0]));
    step(20);
    chk(ceo[2] == 0, "R3 active-low device done", int'(ceo[2]), 0);
    ce2_n = 1;
    step(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule